// File: doc/BRIEF.md
# Four-Phase to Two-Phase Dual-Rail Converter

This block bridges a return-to-zero dual-rail channel onto a transition-signalling dual-rail route. A sender raises exactly one of two input rails to present a bit. The converter answers by flipping the matching output rail once, so one transition on the output carries one token. It then lowers its enable toward the sender. Once the sender has returned both rails to zero, the enable goes high again. Downstream, the receiver acknowledges a token by toggling a single wire.

The handshake wires are sampled by a synchronous clock. The output toggle is not computed from the live receiver acknowledge. It uses a private copy of that acknowledge, taken when the previous token finished. An acknowledge that arrives while the sender still holds its rail high therefore cannot flip the output a second time. A new token is admitted only after the receiver has acknowledged the previous one. A code with both input rails high is refused and raises an error flag.

Top module: `four_to_two_conv`

## Requirements
- R1: In a cycle where the enable `in_ack_o` is high and exactly one input rail is high, the next clock edge inverts only the matching output rail (`in_f_i` maps to `out_f_o`, `in_t_i` maps to `out_t_o`). The other output rail keeps its value.
- R2: On the clock edge that toggles an output rail, `in_ack_o` goes low. It stays low until that token has drained.
- R3: While `in_ack_o` is low, neither output rail changes, whatever the input rails or `out_ack_i` do. In particular, an acknowledge toggle that arrives while an input rail is still high causes no second toggle.
- R4: `in_ack_o` rises on the edge after a cycle in which both input rails are low and `out_ack_i` equals `out_f_o XOR out_t_o`. It does not rise while either condition fails.
- R5: After reset, `in_ack_o` is 1, both output rails are 0, `err_o` is 0 and the stored acknowledge copy is 0.
- R6: When both input rails are high in a cycle, `err_o` is 1 after the next edge and no output rail toggles. Otherwise `err_o` is 0 after the next edge.
- R7: Whenever `in_ack_o` is high, the stored acknowledge copy equals `out_f_o XOR out_t_o`. Each toggle therefore moves the output parity away from `out_ack_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_f_i | input | 1 | Four-phase false rail from the sender |
| in_t_i | input | 1 | Four-phase true rail from the sender |
| in_ack_o | output | 1 | Enable to the sender; high means ready for a token |
| out_f_o | output | 1 | Two-phase false rail; one flip carries a zero |
| out_t_o | output | 1 | Two-phase true rail; one flip carries a one |
| out_ack_i | input | 1 | Two-phase acknowledge; it equals the rail parity once the token is consumed |
| err_o | output | 1 | Registered flag for an illegal code with both input rails high |

## Verification
The bound checker watches five rules on every cycle:
- the output rails never move while the enable is low, and never both at once;
- a toggle always drops the enable;
- the enable rises only after a neutral input together with a matching acknowledge;
- the stored acknowledge copy agrees with the rail parity whenever the converter is ready;
- the error flag follows an illegal code.

Only the bench can show that the right rail flips for a given data value over long sequences. It also covers the effect of an early acknowledge during a long-held input, and the refusal to admit a token before the receiver has answered.

// File: rtl/ftt_pkg.sv
package ftt_pkg;
  localparam int unsigned NUM_RAILS = 2;
  localparam int unsigned RAIL_F    = 0;
  localparam int unsigned RAIL_T    = 1;

  typedef enum logic [0:0] {
    ST_READY = 1'b0,
    ST_DRAIN = 1'b1
  } ftt_state_e;
endpackage

// File: rtl/ftt_rail_reg.sv
module ftt_rail_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic peer_i,
  input  logic ref_i,
  output logic rail_o
);
  // New level is the XNOR of peer rail and stored ack copy: flips parity off ref.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rail_o <= 1'b0;
    else if (fire_i) rail_o <= ~(peer_i ^ ref_i);
  end
endmodule

// File: rtl/ftt_ctrl.sv
module ftt_ctrl
  import ftt_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_RAILS-1:0] rails_in_i,
  input  logic [NUM_RAILS-1:0] rails_out_i,
  input  logic                 ack_i,
  output logic [NUM_RAILS-1:0] fire_o,
  output logic                 ack_copy_o,
  output logic                 en_o
);
  ftt_state_e state_q, state_d;
  logic legal, neutral, acked;

  assign legal   = $onehot(rails_in_i);
  assign neutral = (rails_in_i == '0);
  assign acked   = (ack_i == ^rails_out_i);
  assign en_o    = (state_q == ST_READY);
  assign fire_o  = (en_o && legal) ? rails_in_i : '0;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_READY: if (|fire_o)          state_d = ST_DRAIN;
      ST_DRAIN: if (neutral && acked) state_d = ST_READY;
      default:                        state_d = ST_READY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_READY;
      ack_copy_o <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_DRAIN && neutral && acked) ack_copy_o <= ack_i;
    end
  end
endmodule

// File: rtl/ftt_err.sv
module ftt_err
  import ftt_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_RAILS-1:0] rails_in_i,
  output logic                 err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= ($countones(rails_in_i) > 1);
  end
endmodule

// File: rtl/four_to_two_conv.sv
module four_to_two_conv
  import ftt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_f_i,
  input  logic in_t_i,
  output logic in_ack_o,
  output logic out_f_o,
  output logic out_t_o,
  input  logic out_ack_i,
  output logic err_o
);
  logic [NUM_RAILS-1:0] rails_in, rails_out, fire;
  logic ack_copy;

  assign rails_in[RAIL_F] = in_f_i;
  assign rails_in[RAIL_T] = in_t_i;

  ftt_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rails_in_i (rails_in),
    .rails_out_i(rails_out),
    .ack_i      (out_ack_i),
    .fire_o     (fire),
    .ack_copy_o (ack_copy),
    .en_o       (in_ack_o)
  );

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
    ftt_rail_reg u_rail (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .fire_i(fire[g]),
      .peer_i(rails_out[NUM_RAILS-1-g]),
      .ref_i (ack_copy),
      .rail_o(rails_out[g])
    );
  end

  ftt_err u_err (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rails_in_i(rails_in),
    .err_o     (err_o)
  );

  assign out_f_o = rails_out[RAIL_F];
  assign out_t_o = rails_out[RAIL_T];
endmodule

// File: rtl/ftt_checker.sv
module ftt_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic in_f_i,
  input logic in_t_i,
  input logic in_ack_o,
  input logic out_f_o,
  input logic out_t_o,
  input logic out_ack_i,
  input logic err_o,
  input logic ack_copy
);
  assert_single_toggle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!$stable(out_f_o) && !$stable(out_t_o)));

  assert_toggle_drops_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(out_f_o) || !$stable(out_t_o)) |-> !in_ack_o);

  assert_frozen_when_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ack_o |=> ($stable(out_f_o) && $stable(out_t_o)));

  assert_en_rise_cond_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_ack_o) |-> ($past(!in_f_i && !in_t_i) && $past(out_ack_i == (out_f_o ^ out_t_o))));

  assert_copy_matches_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ack_o |-> (ack_copy == (out_f_o ^ out_t_o)));

  assert_err_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_f_i && in_t_i) |=> err_o);
endmodule

bind four_to_two_conv ftt_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .in_f_i   (in_f_i),
  .in_t_i   (in_t_i),
  .in_ack_o (in_ack_o),
  .out_f_o  (out_f_o),
  .out_t_o  (out_t_o),
  .out_ack_i(out_ack_i),
  .err_o    (err_o),
  .ack_copy (ack_copy)
);

// File: tb/four_to_two_conv_test.sv
`timescale 1ns/1ps
module four_to_two_conv_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_f = 1'b0, in_t = 1'b0, rx_ack = 1'b0;
  logic in_ack, out_f, out_t, err;
  int checks = 0, failures = 0;
  logic exp_f = 1'b0, exp_t = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  four_to_two_conv uut (
    .clk_i(clk), .rst_ni(rst_n), .in_f_i(in_f), .in_t_i(in_t),
    .in_ack_o(in_ack), .out_f_o(out_f), .out_t_o(out_t),
    .out_ack_i(rx_ack), .err_o(err)
  );

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // One token: value v, early ack during hold if early, ack delay after neutral.
  task automatic send(logic v, int hold, bit early, int ack_dly);
    check("R4 ready", {3'b0, in_ack}, 4'h1);
    if (v) in_t = 1'b1; else in_f = 1'b1;
    step();
    if (v) exp_t = ~exp_t; else exp_f = ~exp_f;
    check("R1 toggle", {2'b0, out_f, out_t}, {2'b0, exp_f, exp_t});
    check("R2 en low", {3'b0, in_ack}, 4'h0);
    for (int i = 0; i < hold; i++) begin
      if (early && i == 0) rx_ack = exp_f ^ exp_t;
      step();
      check("R3 held", {1'b0, out_f, out_t, in_ack}, {1'b0, exp_f, exp_t, 1'b0});
    end
    in_f = 1'b0; in_t = 1'b0;
    for (int i = 0; i < ack_dly && !early; i++) begin
      step();
      check("R4 waits ack", {1'b0, out_f, out_t, in_ack}, {1'b0, exp_f, exp_t, 1'b0});
    end
    rx_ack = exp_f ^ exp_t;
    step();
    check("R4 en back", {3'b0, in_ack}, 4'h1);
    check("R6 no err", {3'b0, err}, 4'h0);
  endtask

  initial begin
    repeat (3) step();
    check("R5 reset", {out_f, out_t, in_ack, err}, 4'b0010);
    rst_n = 1'b1;
    step();
    check("R5 after release", {out_f, out_t, in_ack, err}, 4'b0010);
    // Exhaustive sweep of 6-bit token sequences with varied timing.
    for (int s = 0; s < 64; s++) begin
      for (int b = 0; b < 6; b++) send(s[b], (s + b) % 4, ((s >> 1) ^ b) % 3 == 0, (s + 2 * b) % 4);
    end
    // Illegal code in ready state.
    in_f = 1'b1; in_t = 1'b1;
    step();
    check("R6 err set", {out_f, out_t, in_ack, err}, {exp_f, exp_t, 2'b11});
    step();
    check("R6 still no toggle", {1'b0, out_f, out_t, err}, {1'b0, exp_f, exp_t, 1'b1});
    in_f = 1'b0; in_t = 1'b0;
    step();
    check("R6 err clear", {3'b0, err}, 4'h0);
    // Illegal code while draining.
    in_t = 1'b1; step(); exp_t = ~exp_t;
    in_f = 1'b1; step();
    check("R6 err in drain", {out_f, out_t, in_ack, err}, {exp_f, exp_t, 2'b01});
    in_f = 1'b0; in_t = 1'b0; rx_ack = exp_f ^ exp_t;
    step();
    check("R7 parity after drain", {2'b0, in_ack, out_f ^ out_t}, {2'b0, 1'b1, rx_ack});
    send(1'b0, 2, 1'b1, 0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule